// File: doc/BRIEF.md
# Timer-compare interrupt sequencer

This block pairs an 8-bit timer with the interrupt-entry logic of a small in-order processor. A free-running prescaler feeds the timer. When the count equals a compare value on a timer tick, a sticky compare flag is raised. Software can read the flag through a register read port and clear it by writing a one. The same flag, gated by a local enable and by the global interrupt enable, asks for a vector.

The processor is reduced to a few strobes. One strobe marks the first cycle of each instruction and comes with that instruction's length in cycles. Two qualifiers mark an instruction as set-enable or as return-from-interrupt. The block decides at each instruction boundary whether a vector is taken. It then runs the entry sequence, during which it holds the processor with a stall, and it accounts for the return sequence.

The flag becomes visible one cycle after its set edge. A vector is only considered at the end of an instruction. As a result, software can see the flag as 1 for a whole instruction before hardware clears it.

Top module: `tmr_irq_top`

## Requirements
- R1: `clk_sel` picks the timer clock: 1 gives one tick per core cycle, 2 one per 8, 3 one per 64, 4 one per 256, 5 one per 1024; the prescaler counts from reset, so with compare value N the first flag is visible in core cycle (N+1)*D after reset release for divide D.
- R2: The 8-bit count wraps, so compare events recur every 256 ticks (256 core cycles at `clk_sel`=1).
- R3: A vector is taken only at the last cycle of an instruction. The instruction running in the cycle in which the flag first reads 1 completes, and `vec_take` pulses in the cycle right after that instruction's last cycle.
- R4: After a set-enable instruction (`sei_evt`=1) raises the global enable, at least one further instruction completes before a pending vector is taken.
- R5: A return instruction (`reti_evt`=1) occupies 4 cycles whatever `insn_len` says, with `stall` high in its last 3. It sets the global enable at its end, and one further instruction completes before a pending vector is taken.
- R6: Taking a vector clears the compare flag and the global enable at the start of the entry sequence, so `flag_rd` and `gie` read 0 from the `vec_take` cycle onward.
- R7: The entry sequence lasts 3 cycles. `vec_take` is high only in the first of them, and `stall` is high in all three. No instruction may start while `stall` is high.
- R8: A write with `flag_wdata`=1 clears the flag for the next cycle. A write with `flag_wdata`=0 leaves it set.
- R9: With `irq_en`=0, or with the global enable clear, a set flag stays pending and no vector is taken.
- R10: With `clk_sel` = 0 (also 6 or 7) the timer does not advance and the flag never sets.
- R11: After reset `flag_rd`, `gie`, `stall` and `vec_take` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Timer clock select (R1 encoding) |
| cmp_val | input | 8 | Compare value |
| irq_en | input | 1 | Local enable of the compare interrupt |
| flag_wr | input | 1 | Write strobe of the flag register |
| flag_wdata | input | 1 | Write data; 1 clears the flag |
| insn_start | input | 1 | First cycle of an instruction |
| insn_len | input | 3 | Length in cycles (1 to 7) of the starting instruction |
| sei_evt | input | 1 | Starting instruction sets the global enable |
| reti_evt | input | 1 | Starting instruction is a return-from-interrupt |
| flag_rd | output | 1 | Read data of the compare flag |
| vec_take | output | 1 | One-cycle pulse: vector taken, entry begins |
| stall | output | 1 | Instruction still running or entry in progress |
| gie | output | 1 | Global interrupt enable |

## Verification
The hardest situation to reach is a flag set edge that falls at each possible phase of a multi-cycle instruction. The race window only shows when the set edge and the instruction boundaries line up in a particular way. The bench counts core cycles from reset release and issues back-to-back instructions of a fixed length. It varies the compare value, so the set edge lands on the first, middle and last cycle of an instruction. From its own schedule it predicts the cycle in which the vector must follow. The return rule needs a flag that pends while the handler runs. To get one, the bench stays in the handler with the enable clear for a whole timer period before it returns.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

   // clock-select code -> log2 of the divide ratio; codes 0,6,7 stop the timer
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned SEL_MAX = 5;

   function automatic int unsigned div_shift(input int unsigned sel);
      case (sel)
         1:       return 0;
         2:       return 3;
         3:       return 6;
         4:       return 8;
         5:       return 10;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tmr_irq_prescaler.sv
module tmr_irq_prescaler
   import tmr_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] clk_sel,
   output logic             tick
);
   localparam int unsigned PSC_W = div_shift(SEL_MAX);
   localparam int unsigned NSEL  = 2 ** SEL_W;

   logic [PSC_W-1:0] psc_q;
   logic [NSEL-1:0]  tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psc_q <= '0;
      else        psc_q <= psc_q + 1'b1;
   end

   for (genvar s = 0; s < NSEL; s++) begin : g_tap
      localparam int unsigned SH = div_shift(s);
      if (s == 0 || s > SEL_MAX) begin : g_off
         assign tap[s] = 1'b0;
      end else if (SH == 0) begin : g_full
         assign tap[s] = 1'b1;
      end else begin : g_div
         assign tap[s] = &psc_q[SH-1:0];
      end
   end

   assign tick = tap[clk_sel];

   // R10: a stopped selection never yields a tick
   a_r10_off_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == '0) |-> !tick);

endmodule

// File: rtl/tmr_irq_counter.sv
module tmr_irq_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             hw_clr,
   input  logic             wr_en,
   input  logic             wr_data,
   output logic             hit,
   output logic             flag
);
   if (CNT_W < 2) begin : g_chk_w
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   assign hit = tick && (cnt_q == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   // a new match wins over any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           flag_q <= 1'b0;
      else if (hit)                         flag_q <= 1'b1;
      else if (hw_clr || (wr_en && wr_data)) flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R8: writing zero never drops a set flag
   a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_en && !wr_data && !hw_clr) |=> flag_q);

endmodule

// File: rtl/tmr_irq_seq.sv
module tmr_irq_seq
   import tmr_irq_pkg::*;
#(
   parameter int unsigned LEN_W     = 3,
   parameter int unsigned ENTRY_CYC = 3,
   parameter int unsigned RETI_CYC  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             insn_start,
   input  logic [LEN_W-1:0] insn_len,
   input  logic             sei_evt,
   input  logic             reti_evt,
   input  logic             flag,
   input  logic             local_en,
   output logic             take,
   output logic             vec_take,
   output logic             stall,
   output logic             gie
);
   localparam int unsigned MAXLEN = max_u((2 ** LEN_W) - 1, RETI_CYC);
   localparam int unsigned REM_W  = $clog2(MAXLEN);
   localparam int unsigned LW     = REM_W + 1;
   localparam int unsigned ENT_W  = $clog2(ENTRY_CYC + 1);

   if (LEN_W < 2)    begin : g_chk_len   $error("LEN_W must be at least 2"); end
   if (ENTRY_CYC < 1) begin : g_chk_ent  $error("ENTRY_CYC must be at least 1"); end
   if (RETI_CYC < 2) begin : g_chk_reti  $error("RETI_CYC must be at least 2"); end

   logic [REM_W-1:0] rem_q;
   logic [ENT_W-1:0] ent_q;
   logic             gie_q;
   logic             en_pend_q;
   logic [LW-1:0]    eff_len;
   logic             bnd;
   logic             en_evt;

   always_comb begin
      eff_len = reti_evt ? LW'(RETI_CYC) : {{(LW-LEN_W){1'b0}}, insn_len};
      bnd     = insn_start ? (eff_len == LW'(1)) : (rem_q == REM_W'(1));
      en_evt  = insn_start ? (sei_evt || reti_evt) : en_pend_q;
      take    = bnd && flag && local_en && gie_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q     <= '0;
         en_pend_q <= 1'b0;
      end else if (insn_start) begin
         rem_q     <= REM_W'(eff_len - LW'(1));
         en_pend_q <= sei_evt || reti_evt;
      end else if (rem_q != '0) begin
         rem_q     <= rem_q - 1'b1;
      end
   end

   // enable rises only at the end of the enabling instruction, so the take
   // test of the next boundary is the earliest one that can see it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gie_q <= 1'b0;
      else if (take)           gie_q <= 1'b0;
      else if (bnd && en_evt)  gie_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ent_q <= '0;
      else if (take)           ent_q <= ENT_W'(ENTRY_CYC);
      else if (ent_q != '0)    ent_q <= ent_q - 1'b1;
   end

   assign vec_take = (ent_q == ENT_W'(ENTRY_CYC));
   assign stall    = (ent_q != '0) || (rem_q != '0);
   assign gie      = gie_q;

   // R7: the processor must not start an instruction while held
   a_r7_no_issue_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      insn_start |-> !stall);
   // R7: entry pulse is single and holds the processor
   a_r7_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      vec_take |-> (stall && !gie_q));
   a_r7_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
      vec_take |=> !vec_take);
   // R5: return occupies further cycles after its first
   a_r5_reti_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_start && reti_evt) |=> (stall && !gie_q));

endmodule

// File: rtl/tmr_irq_top.sv
module tmr_irq_top
   import tmr_irq_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned LEN_W     = 3,
   parameter int unsigned ENTRY_CYC = 3,
   parameter int unsigned RETI_CYC  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             irq_en,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   input  logic             insn_start,
   input  logic [LEN_W-1:0] insn_len,
   input  logic             sei_evt,
   input  logic             reti_evt,
   output logic             flag_rd,
   output logic             vec_take,
   output logic             stall,
   output logic             gie
);
   logic tick;
   logic cmp_hit;
   logic take;
   logic flag_q;

   tmr_irq_prescaler u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .tick    (tick)
   );

   tmr_irq_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cmp_val (cmp_val),
      .hw_clr  (take),
      .wr_en   (flag_wr),
      .wr_data (flag_wdata),
      .hit     (cmp_hit),
      .flag    (flag_q)
   );

   tmr_irq_seq #(
      .LEN_W     (LEN_W),
      .ENTRY_CYC (ENTRY_CYC),
      .RETI_CYC  (RETI_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_start (insn_start),
      .insn_len   (insn_len),
      .sei_evt    (sei_evt),
      .reti_evt   (reti_evt),
      .flag       (flag_q),
      .local_en   (irq_en),
      .take       (take),
      .vec_take   (vec_take),
      .stall      (stall),
      .gie        (gie)
   );

   assign flag_rd = flag_q;

   // R3: a vector follows a cycle in which the flag was visible and enabled
   a_r3_flag_before_take: assert property (@(posedge clk) disable iff (!rst_n)
      vec_take |-> $past(flag_q && irq_en));
   // R6: entry starts with the flag already cleared
   a_r6_take_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_take && !$past(cmp_hit)) |-> !flag_q);
   // R8: write-one clears
   a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && flag_wdata && !cmp_hit) |=> !flag_q);
   // R9: masked source never vectors
   a_r9_local_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !vec_take);
   // R10: stopped timer never raises the flag
   a_r10_off_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |=> !$rose(flag_q));

endmodule

// File: tb/test_tmr_irq_top.sv
module test_tmr_irq_top;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;
   localparam int TBL_CMP [NV] = '{20, 21, 22, 24, 25, 30, 19};
   localparam int TBL_LEN [NV] = '{1, 2, 3, 3, 4, 4, 2};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] clk_sel = 3'd1;
   logic [7:0] cmp_val = 8'd0;
   logic       irq_en = 1'b0;
   logic       flag_wr = 1'b0;
   logic       flag_wdata = 1'b0;
   logic       insn_start = 1'b0;
   logic [2:0] insn_len = 3'd1;
   logic       sei_evt = 1'b0;
   logic       reti_evt = 1'b0;
   logic       flag_rd, vec_take, stall, gie;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_irq_top i_tmr_irq_top (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cmp_val(cmp_val),
      .irq_en(irq_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .insn_start(insn_start), .insn_len(insn_len), .sei_evt(sei_evt),
      .reti_evt(reti_evt), .flag_rd(flag_rd), .vec_take(vec_take),
      .stall(stall), .gie(gie)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
      cyc++;
      insn_start = 1'b0; insn_len = 3'd1; sei_evt = 1'b0; reti_evt = 1'b0;
      flag_wr = 1'b0; flag_wdata = 1'b0;
   endtask

   task automatic issue(input int len, input bit s, input bit r);
      insn_start = 1'b1; insn_len = 3'(len); sei_evt = s; reti_evt = r;
   endtask

   task automatic do_reset(input logic [2:0] sel, input int cmp, input bit en);
      rst_n = 1'b0; clk_sel = sel; cmp_val = 8'(cmp); irq_en = en;
      insn_start = 1'b0; sei_evt = 1'b0; reti_evt = 1'b0; flag_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // time to first flag for a given selection
   task automatic first_flag(input logic [2:0] sel, input int cmp, input int exp, input string req);
      int got = -1;
      do_reset(sel, cmp, 1'b0);
      for (int k = 0; k < 1200 && got < 0; k++) begin
         nxt();
         if (flag_rd) got = cyc;
      end
      chk(req, got, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin : main
      int bad;
      int s;
      // R11: reset state
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 flag", flag_rd, 0);
      chk("R11 gie", gie, 0);
      chk("R11 stall", stall, 0);
      chk("R11 vec_take", vec_take, 0);

      // R10: stopped timer
      do_reset(3'd0, 0, 1'b0);
      bad = 0;
      for (int k = 0; k < 400; k++) begin nxt(); if (flag_rd) bad++; end
      chk("R10 flag sets while stopped", bad, 0);

      // R1: prescaler ratios
      first_flag(3'd1, 10, 11, "R1 div1 first flag cycle");
      first_flag(3'd2, 3, 32, "R1 div8 first flag cycle");
      first_flag(3'd5, 0, 1024, "R1 div1024 first flag cycle");

      // R3/R6/R7/R2: table of compare values and instruction lengths
      for (int v = 0; v < NV; v++) begin
         int bl, c0, exp_take, got_take, nstall, npulse;
         do_reset(3'd1, TBL_CMP[v], 1'b1);
         nxt(); issue(1, 1'b1, 1'b0);              // set-enable at cycle 1
         bl = 0; c0 = -1; exp_take = -1; got_take = -1;
         for (int k = 0; k < 200 && got_take < 0; k++) begin
            nxt();
            if (vec_take) begin
               got_take = cyc;
               chk("R6 flag cleared at entry", flag_rd, 0);
               chk("R6 gie cleared at entry", gie, 0);
            end else begin
               if (bl == 0) begin
                  if (stall) chk("R7 stall with no instruction", stall, 0);
                  issue(TBL_LEN[v], 1'b0, 1'b0);
                  bl = TBL_LEN[v];
               end
               if (c0 < 0 && flag_rd) begin c0 = cyc; exp_take = cyc + bl; end
               bl--;
            end
         end
         chk("R2 flag visible cycle", c0, TBL_CMP[v] + 1);
         chk("R3 vector after running instruction", got_take, exp_take);
         nstall = 0; npulse = 0;
         for (int k = 0; k < 8; k++) begin
            if (stall) nstall++;
            if (vec_take) npulse++;
            if (flag_rd) chk("R6 flag read during entry", flag_rd, 0);
            nxt();
         end
         chk("R7 entry stall cycles", nstall, 3);
         chk("R7 vec_take pulses", npulse, 1);
      end

      // R9/R8/R2/R4/R5 directed sequence, compare at 5
      do_reset(3'd1, 5, 1'b1);
      bad = 0;
      for (int k = 0; k < 20; k++) begin nxt(); issue(1, 1'b0, 1'b0); if (vec_take) bad++; end
      chk("R9 no vector with enable clear", bad, 0);
      chk("R9 flag pending", flag_rd, 1);
      nxt(); flag_wr = 1'b1; flag_wdata = 1'b0;
      nxt(); chk("R8 write zero keeps flag", flag_rd, 1);
      flag_wr = 1'b1; flag_wdata = 1'b1;
      nxt(); chk("R8 write one clears flag", flag_rd, 0);
      s = -1;
      for (int k = 0; k < 400 && s < 0; k++) begin nxt(); if (flag_rd) s = cyc; end
      chk("R2 period of 256", s, 262);
      // R4: set-enable then a 2-cycle instruction
      nxt(); issue(1, 1'b1, 1'b0); chk("R4 no vector at set-enable", vec_take, 0);
      nxt(); chk("R4 gie raised", gie, 1); chk("R4 flag readable after enable", flag_rd, 1);
      issue(2, 1'b0, 1'b0); chk("R4 no vector yet", vec_take, 0);
      nxt(); chk("R4 no vector mid instruction", vec_take, 0);
      nxt(); chk("R4 vector after one instruction", vec_take, 1);
      nxt(); nxt(); nxt();
      chk("R7 stall released", stall, 0);
      // handler: wait a full period with enable clear so the flag pends
      bad = 0;
      for (int k = 0; k < 300 && !flag_rd; k++) begin nxt(); issue(1, 1'b0, 1'b0); if (vec_take) bad++; end
      chk("R9 no vector inside handler", bad, 0);
      nxt(); chk("R5 flag pending before return", flag_rd, 1);
      issue(1, 1'b0, 1'b1);
      bad = 0;
      for (int k = 0; k < 3; k++) begin
         nxt();
         if (!stall || vec_take || gie) bad++;
      end
      chk("R5 return busy 3 more cycles", bad, 0);
      nxt(); chk("R5 stall free after return", stall, 0);
      chk("R5 gie set after return", gie, 1);
      chk("R5 no vector at return end", vec_take, 0);
      issue(1, 1'b0, 1'b0);
      nxt(); chk("R5 vector after one instruction", vec_take, 1);

      // R9: local enable clear
      do_reset(3'd1, 5, 1'b0);
      nxt(); issue(1, 1'b1, 1'b0);
      bad = 0;
      for (int k = 0; k < 40; k++) begin nxt(); issue(1, 1'b0, 1'b0); if (vec_take) bad++; end
      chk("R9 masked source no vector", bad, 0);
      chk("R9 masked flag still set", flag_rd, 1);
      chk("R9 gie still set", gie, 1);

      done = 1'b1;
      report();
      $finish;
   end
endmodule